// File: doc/BRIEF.md
# Mode-Switched Serial Loader with Status Readback

This block receives a bit-serial stream into a shift register whose active length follows a mode input. In grayscale mode it holds one 12-bit word per channel (192 bits for 16 channels). In correction mode it holds one 6-bit word per channel (96 bits). A latch strobe copies the shifted contents into the grayscale register or the correction register. Several blocks can be chained by feeding one block's serial output into the next block's serial input. The serial output is the bit leaving the far end of the active length.

The serial clock and the latch are level inputs sampled in the system clock domain. A rising serial clock, detected against a registered copy, is one shift step. The serial link has no back-pressure: every detected rise consumes one input bit and advances one output bit, and the controller paces the stream. There is therefore no valid/ready pair on the stream. Control and status pins are plain levels.

After a grayscale latch the shift register is overwritten with a 192-bit status word. The controller reads that word back on the serial output while it shifts in the next grayscale frame.

Top module: `mode_serial_loader`

## Requirements
- R1: A shift step happens only on a rising serial clock. The register moves one place toward its top bit and the serial input enters bit 0. With the serial clock steady, the contents stay unchanged whatever the serial input does.
- R2: The serial output is bit 191 of the shift register in grayscale mode (mode low) and bit 95 in correction mode (mode high). A bit shifted in therefore reappears on the serial output after 192 or 96 steps.
- R3: While the latch is high in grayscale mode, the grayscale output follows the shift register. While the latch is low, it holds its value.
- R4: While the latch is high in correction mode, the correction output follows shift bits 95:0. Channel n sits in bits 6n+5..6n, so channel 15's bit 5 is the first bit sent. The correction output holds while the latch is low or the mode is grayscale.
- R5: In the grayscale output, channel n sits in bits 12n+11..12n, so channel 15's word is sent first, MSB first.
- R6: When the latch falls in grayscale mode, the shift register is loaded with a status word: bit n (n = 0..15) holds the open-LED flag of channel n, bit 16 holds the thermal flag, bits 119:24 hold the correction register, and every other bit is 0.
- R7: The top bit of the status word is on the serial output as soon as the word is loaded, with no extra serial clock. Each following rise presents the next lower bit while a new input bit is shifted in.
- R8: The first grayscale latch after a correction latch does not change the grayscale output. The next rising serial clock completes the update: the grayscale output takes the shift contents as they stood, the serial input bit of that rise is discarded, and the status word is loaded.
- R9: A mode change while the latch is high is ignored until the latch is low. During that time the error output goes high one cycle after the mismatch is seen.
- R10: Reset clears both registers, the shift register and the error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock level; a rise is one shift step |
| sin_i | input | 1 | Serial data input |
| latch_i | input | 1 | Level latch strobe |
| mode_i | input | 1 | 0 = grayscale frame, 1 = correction frame |
| open_i | input | 16 | Per-channel open-LED flags |
| therm_i | input | 1 | Over-temperature flag |
| sout_o | output | 1 | Serial data output |
| gs_o | output | 192 | Grayscale register, 12 bits per channel |
| dc_o | output | 96 | Correction register, 6 bits per channel |
| mode_err_o | output | 1 | Mode changed while the latch was high |

## Verification
The hardest state to reach from the ports is the deferred grayscale update. It only happens after a full correction frame has been latched, the mode has been switched back, and a full grayscale frame has been shifted and latched. The stimulus follows exactly that order. It checks the untouched grayscale output between the latch pulse and the extra clock, then reads the status word back while shifting the next frame in. A second status readback with different flags, and a mode flip held inside a latch pulse, cover the status layout and the ignored mode change.

// File: rtl/mser_pkg.sv
package mser_pkg;
  parameter int unsigned MSER_CH  = 16;
  parameter int unsigned MSER_GSW = 12;
  parameter int unsigned MSER_DCW = 6;

  typedef enum logic [1:0] {
    ST_PLAIN    = 2'd0,
    ST_DC_SEEN  = 2'd1,
    ST_GS_ARMED = 2'd2
  } seq_t;
endpackage

// File: rtl/mser_ctrl.sv
module mser_ctrl
  import mser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic latch_i,
  input  logic mode_i,
  output logic mode_eff_o,
  output logic gs_copy_o,
  output logic dc_copy_o,
  output logic st_load_o,
  output logic complete_o,
  output logic shift_en_o,
  output logic mode_err_o
);
  logic sclk_q, latch_q;
  logic sclk_rise, latch_fall;
  seq_t state_q;

  assign sclk_rise  = sclk_i & ~sclk_q;
  assign latch_fall = ~latch_i & latch_q;

  assign gs_copy_o  = latch_i & ~mode_eff_o & (state_q == ST_PLAIN);
  assign dc_copy_o  = latch_i & mode_eff_o;
  assign st_load_o  = latch_fall & ~mode_eff_o & (state_q == ST_PLAIN);
  assign complete_o = sclk_rise & ~latch_i & (state_q == ST_GS_ARMED);
  assign shift_en_o = sclk_rise & ~complete_o & ~st_load_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      latch_q    <= 1'b0;
      mode_eff_o <= 1'b0;
      mode_err_o <= 1'b0;
    end else begin
      sclk_q     <= sclk_i;
      latch_q    <= latch_i;
      if (!latch_i) mode_eff_o <= mode_i;
      mode_err_o <= latch_i & (mode_i != mode_eff_o);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_PLAIN;
    end else if (dc_copy_o) begin
      state_q <= ST_DC_SEEN;
    end else if (latch_fall && !mode_eff_o && state_q == ST_DC_SEEN) begin
      state_q <= ST_GS_ARMED;
    end else if (complete_o) begin
      state_q <= ST_PLAIN;
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> $stable(mode_eff_o)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> $past(latch_i)); // R9
endmodule

// File: rtl/mser_status.sv
module mser_status
  import mser_pkg::*;
#(
  parameter int unsigned CH  = MSER_CH,
  parameter int unsigned GSW = MSER_GSW,
  parameter int unsigned DCW = MSER_DCW
)(
  input  logic [CH-1:0]       open_i,
  input  logic                therm_i,
  input  logic [CH*DCW-1:0]   dc_i,
  output logic [CH*GSW-1:0]   word_o
);
  localparam int unsigned LEN     = CH * GSW;
  localparam int unsigned DC_LEN  = CH * DCW;
  localparam int unsigned DC_BASE = ((CH + 1 + 7) / 8) * 8;

  always_comb begin
    word_o = '0;
    word_o[CH-1:0]             = open_i;
    word_o[CH]                 = therm_i;
    word_o[DC_BASE +: DC_LEN]  = dc_i;
  end

  initial begin
    if (DC_BASE + DC_LEN > LEN) $display("mser_status: status word does not fit");
  end
endmodule

// File: rtl/mser_shift.sv
module mser_shift
  import mser_pkg::*;
#(
  parameter int unsigned CH  = MSER_CH,
  parameter int unsigned GSW = MSER_GSW,
  parameter int unsigned DCW = MSER_DCW
)(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_en_i,
  input  logic                 load_i,
  input  logic                 sin_i,
  input  logic                 mode_eff_i,
  input  logic [CH*GSW-1:0]    status_i,
  input  logic [CH*DCW-1:0]    dc_i,
  output logic [CH*GSW-1:0]    sr_o,
  output logic                 sout_o
);
  localparam int unsigned LEN     = CH * GSW;
  localparam int unsigned DC_LEN  = CH * DCW;
  localparam int unsigned DC_BASE = ((CH + 1 + 7) / 8) * 8;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         sr_o <= '0;
    else if (load_i)     sr_o <= status_i;
    else if (shift_en_i) sr_o <= {sr_o[LEN-2:0], sin_i};
  end

  assign sout_o = mode_eff_i ? sr_o[DC_LEN-1] : sr_o[LEN-1];

  AST_SHIFT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !load_i) |=> $stable(sr_o)); // R1
  AST_STATUS_DC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sr_o[DC_BASE +: DC_LEN] == $past(dc_i))); // R6
endmodule

// File: rtl/mser_regs.sv
module mser_regs
  import mser_pkg::*;
#(
  parameter int unsigned CH  = MSER_CH,
  parameter int unsigned GSW = MSER_GSW,
  parameter int unsigned DCW = MSER_DCW
)(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gs_copy_i,
  input  logic                complete_i,
  input  logic                dc_copy_i,
  input  logic [CH*GSW-1:0]   sr_i,
  output logic [CH*GSW-1:0]   gs_o,
  output logic [CH*DCW-1:0]   dc_o
);
  localparam int unsigned DC_LEN = CH * DCW;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                       gs_o <= '0;
    else if (gs_copy_i || complete_i)  gs_o <= sr_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        dc_o <= '0;
    else if (dc_copy_i) dc_o <= sr_i[DC_LEN-1:0];
  end

  AST_GS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gs_copy_i && !complete_i) |=> $stable(gs_o)); // R3
  AST_DC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dc_copy_i |=> $stable(dc_o)); // R4
endmodule

// File: rtl/mode_serial_loader.sv
module mode_serial_loader
  import mser_pkg::*;
#(
  parameter int unsigned CH  = MSER_CH,
  parameter int unsigned GSW = MSER_GSW,
  parameter int unsigned DCW = MSER_DCW
)(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                sin_i,
  input  logic                latch_i,
  input  logic                mode_i,
  input  logic [CH-1:0]       open_i,
  input  logic                therm_i,
  output logic                sout_o,
  output logic [CH*GSW-1:0]   gs_o,
  output logic [CH*DCW-1:0]   dc_o,
  output logic                mode_err_o
);
  localparam int unsigned LEN = CH * GSW;

  logic mode_eff, gs_copy, dc_copy, st_load, complete, shift_en;
  logic [LEN-1:0] sr, status_word;

  mser_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .latch_i    (latch_i),
    .mode_i     (mode_i),
    .mode_eff_o (mode_eff),
    .gs_copy_o  (gs_copy),
    .dc_copy_o  (dc_copy),
    .st_load_o  (st_load),
    .complete_o (complete),
    .shift_en_o (shift_en),
    .mode_err_o (mode_err_o)
  );

  mser_status #(.CH(CH), .GSW(GSW), .DCW(DCW)) u_status (
    .open_i  (open_i),
    .therm_i (therm_i),
    .dc_i    (dc_o),
    .word_o  (status_word)
  );

  mser_shift #(.CH(CH), .GSW(GSW), .DCW(DCW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .load_i     (st_load | complete),
    .sin_i      (sin_i),
    .mode_eff_i (mode_eff),
    .status_i   (status_word),
    .dc_i       (dc_o),
    .sr_o       (sr),
    .sout_o     (sout_o)
  );

  mser_regs #(.CH(CH), .GSW(GSW), .DCW(DCW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gs_copy_i  (gs_copy),
    .complete_i (complete),
    .dc_copy_i  (dc_copy),
    .sr_i       (sr),
    .gs_o       (gs_o),
    .dc_o       (dc_o)
  );
endmodule

// File: tb/mode_serial_loader_tb_top.sv
`timescale 1ns/1ps
module mode_serial_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sin = 1'b0, latch = 1'b0, mode = 1'b0, therm = 1'b0;
  logic [15:0]  open_f = '0;
  logic         sout, merr;
  logic [191:0] gs;
  logic [95:0]  dc;

  always #2.5 clk = ~clk;

  mode_serial_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sin_i(sin), .latch_i(latch),
    .mode_i(mode), .open_i(open_f), .therm_i(therm), .sout_o(sout),
    .gs_o(gs), .dc_o(dc), .mode_err_o(merr)
  );

  typedef struct {
    string        req;
    int           kind;   // 0 raw, 1 gs, 2 dc, 3 sout, 4 err
    logic [191:0] exp;
    logic [191:0] act;
  } item_t;

  item_t sb_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [191:0] a;
        it = sb_q.pop_front();
        case (it.kind)
          1: a = gs;
          2: a = {96'd0, dc};
          3: a = {191'd0, sout};
          4: a = {191'd0, merr};
          default: a = it.act;
        endcase
        n_run++;
        if (a !== it.exp) begin
          n_fail++;
          $display("FAIL %s: act=%h exp=%h", it.req, a, it.exp);
        end
      end
    end
  end

  task automatic chk(string req, int kind, logic [191:0] exp, logic [191:0] act = '0);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp; it.act = act;
    sb_q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(int len, logic [191:0] w, output logic [191:0] got);
    got = '0;
    for (int i = len - 1; i >= 0; i--) begin
      got[i] = sout;
      @(negedge clk); sclk = 1'b1; sin = w[i];
      @(negedge clk); sclk = 1'b0;
    end
  endtask

  task automatic strobe();
    @(negedge clk); latch = 1'b1;
    repeat (2) @(negedge clk);
    latch = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [191:0] gs_word(int seed);
    logic [191:0] w = '0;
    for (int n = 0; n < 16; n++) w[n*12 +: 12] = 12'((n * 273 + seed) & 12'hFFF);
    return w;
  endfunction

  function automatic logic [95:0] dc_word(int seed);
    logic [95:0] w = '0;
    for (int n = 0; n < 16; n++) w[n*6 +: 6] = 6'((n * 7 + seed) & 6'h3F);
    return w;
  endfunction

  function automatic logic [191:0] status_word(logic [15:0] o, logic t, logic [95:0] d);
    logic [191:0] w = '0;
    w[15:0]    = o;
    w[16]      = t;
    w[119:24]  = d;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [191:0] got, g1, g2, g3, e, f;
    logic [95:0]  d;
    d  = dc_word(5);
    g1 = gs_word(17);
    g2 = gs_word(901);
    g3 = gs_word(2222);
    e  = {96'd0, dc_word(33)};
    f  = {96'd0, dc_word(50)};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 gs after reset", 1, '0);
    chk("R10 dc after reset", 2, '0);
    chk("R10 sout after reset", 3, '0);
    chk("R10 err after reset", 4, '0);

    // correction frame
    mode = 1'b1; repeat (2) @(negedge clk);
    send(96, {96'd0, d}, got);
    strobe();
    chk("R4 dc register", 2, {96'd0, d});
    chk("R4 channel 15 field", 0, {186'd0, 6'((15 * 7 + 5) & 63)}, {186'd0, dc[90 +: 6]});

    // first grayscale frame after correction: deferred update
    mode = 1'b0; repeat (2) @(negedge clk);
    send(192, g1, got);
    open_f = 16'hA5C3; therm = 1'b1;
    strobe();
    chk("R8 gs held after latch", 1, '0);
    @(negedge clk); sclk = 1'b1; sin = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    chk("R8 gs after extra clock", 1, g1);
    send(192, g2, got);
    chk("R6 R7 status readback 1", 0, status_word(16'hA5C3, 1'b1, d), got);

    // plain grayscale latch
    open_f = 16'h0F01; therm = 1'b0;
    strobe();
    chk("R3 gs follows latch", 1, g2);
    chk("R5 channel 15 field", 0, {180'd0, 12'((15 * 273 + 901) & 12'hFFF)}, {180'd0, gs[180 +: 12]});
    send(192, g3, got);
    chk("R6 status readback 2", 0, status_word(16'h0F01, 1'b0, d), got);
    chk("R3 gs holds while shifting", 1, g2);

    // 96-bit delay line, idle serial input in between
    mode = 1'b1; repeat (2) @(negedge clk);
    send(96, e, got);
    for (int k = 0; k < 6; k++) begin @(negedge clk); sin = ~sin; end
    send(96, f, got);
    chk("R1 R2 correction-length echo", 0, e, got);

    // mode flip during latch high
    @(negedge clk); latch = 1'b1;
    @(negedge clk); mode = 1'b0;
    @(negedge clk);
    chk("R9 error raised", 4, 192'd1);
    chk("R4 dc follows shift", 2, f);
    chk("R9 gs untouched", 1, g2);
    latch = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 error cleared", 4, '0);
    chk("R9 gs after ignored change", 1, g2);
    chk("R2 R9 grayscale tap active", 3, {191'd0, e[95]});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule